// File: doc/BRIEF.md
# Parallel Second/Third-Level Miss Controller

This controller takes one first-level miss at a time, after core arbitration, and resolves it against a second-level and a third-level cache. When the memory-subsystem arbitration slot is won, both levels are probed in the same cycle. The second level answers after a short fixed lookup. The third level answers one cycle later, and its answer counts only when the second level missed. A third-level hit has to start its external access on a rising edge of a clock that runs at a quarter of the processor rate. The controller therefore waits for that edge, then waits out a programmable SRAM latency, then forwards the line to the core.

A pending reload from an earlier miss has priority over the new request, and a castout writeback in progress also holds it back. Both are plain level inputs that stall the arbitration slot. The tag arrays are behavioural direct-mapped models filled through a simple write port. A miss in both levels returns a bus-miss response that carries no data. Requests use a valid/ready handshake, and ready stays low while a request is outstanding.

Top module: `dual_level_fill_ctrl`

## Requirements
- R1: `reqReady` is 1 while no request is outstanding. It drops in the cycle after a handshake (`reqValid` and `reqReady` both 1 at a clock edge) and returns in the cycle in which the response is valid.
- R2: Each cycle after acceptance in which `reloadPending` or `castoutBusy` is 1 delays the arbitration win by one cycle, and every later response time shifts by the same amount.
- R3: Let edge A be the acceptance edge and k the number of stall cycles. On a second-level hit, `respValid` rises at edge A+5+k: one arbitration cycle, three lookup cycles and one forwarding cycle. At that point `respMiss`=0, `respFromL3`=0 and `respData` is the stored second-level line.
- R4: When the second level hits, the third-level contents have no effect. The response carries the second-level data at second-level timing, even if the third level holds the same address with different data.
- R5: Let D = A+5+k, the edge at which the third-level lookup (four cycles) completes. The phase is the number of clock edges since reset release, modulo 4, and phase 0 marks an aligned edge. On a second-level miss and a third-level hit, the wait is w = (4 - D mod 4) mod 4, and `respValid` rises at edge D+w+N+1 with `respFromL3`=1 and the third-level data.
- R6: N is the value of `sramLatency`, sampled at edge D. It defaults to 23 in use and may be set to any value from 1 upward.
- R7: When both levels miss, `respValid` rises at edge D+1 with `respMiss`=1, `respFromL3`=0 and `respData`=0.
- R8: `respValid` is a one-cycle pulse, and `respMiss` and `respFromL3` are 1 only while `respValid` is 1.
- R9: While `rst_n` is 0, `reqReady` is 1 and `respValid` is 0.
- R10: A fill write (`fillValid`=1, `fillLevel` 0 for the second level and 1 for the third) installs a line at index `fillAddr[IDX_W-1:0]` with tag `fillAddr[ADDR_W-1:IDX_W]`, replacing any earlier line at that index. A later lookup of the replaced address misses at that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Miss request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqAddr | input | ADDR_W | Miss address |
| reloadPending | input | 1 | Earlier reload owns arbitration |
| castoutBusy | input | 1 | Castout writeback in progress |
| sramLatency | input | LAT_W | External SRAM access cycles |
| fillValid | input | 1 | Tag-model fill write strobe |
| fillLevel | input | 1 | Fill target: 0 second level, 1 third level |
| fillAddr | input | ADDR_W | Fill address |
| fillData | input | DATA_W | Fill line data |
| respValid | output | 1 | Response pulse |
| respMiss | output | 1 | Response is a bus miss with no data |
| respFromL3 | output | 1 | Response data came from the third level |
| respData | output | DATA_W | Returned line data |

## Verification
The bench uses the default parameters: 16-bit addresses, 32-bit data, eight sets per level, and second/third lookup depths of 3 and 4. This keeps the whole path short enough to predict every edge. The bench drives `sramLatency` at 23, 5 and 1, and it varies the stall count before arbitration, so third-level hits land at different divider phases and more than one alignment wait is exercised. Lines placed at the same address in both levels, and a second-level line overwritten at the same index, cover the ordering and replacement cases.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic capture;   // latch the request address
    logic launch;    // start both level lookups
    logic loadL2;    // take the second-level line
    logic loadL3;    // take the third-level line
    logic sendHit;   // issue a data response
    logic sendMiss;  // issue a bus-miss response
    logic fromL3;    // data response sourced from third level
  } strobe_t;
endpackage

// File: rtl/tag_level_model.sv
module tag_level_model #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 8,
  parameter int LOOKUP_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] lookAddr,
  input  logic              fillEn,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  output logic              done,
  output logic              hit,
  output logic [DATA_W-1:0] data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [SETS-1:0]   lineValid;
  logic [TAG_W-1:0]  lineTag  [SETS];
  logic [DATA_W-1:0] lineData [SETS];

  logic [IDX_W-1:0]  lookIdx, fillIdx;
  logic [TAG_W-1:0]  lookTag, fillTag;
  logic              lookHit;

  logic [LOOKUP_CYC-1:0] stV, stH;
  logic [DATA_W-1:0]     stD [LOOKUP_CYC];

  assign lookIdx = lookAddr[IDX_W-1:0];
  assign lookTag = lookAddr[ADDR_W-1:IDX_W];
  assign fillIdx = fillAddr[IDX_W-1:0];
  assign fillTag = fillAddr[ADDR_W-1:IDX_W];
  assign lookHit = lineValid[lookIdx] && (lineTag[lookIdx] == lookTag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineValid <= '0;
    end else if (fillEn) begin
      lineValid[fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      lineTag[fillIdx]  <= fillTag;
      lineData[fillIdx] <= fillData;
    end
  end

  // Lookup pipeline: result visible LOOKUP_CYC-1 cycles after the launch edge,
  // consumed at the edge closing the last lookup cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stV <= '0;
      stH <= '0;
    end else begin
      stV[0] <= launch;
      stH[0] <= lookHit;
      for (int i = 1; i < LOOKUP_CYC; i++) begin
        stV[i] <= stV[i-1];
        stH[i] <= stH[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    stD[0] <= lineData[lookIdx];
    for (int i = 1; i < LOOKUP_CYC; i++) stD[i] <= stD[i-1];
  end

  assign done = stV[LOOKUP_CYC-1];
  assign hit  = stH[LOOKUP_CYC-1];
  assign data = stD[LOOKUP_CYC-1];
endmodule

// File: rtl/fill_datapath.sv
module fill_datapath
  import lvl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SETS      = 8,
  parameter int L2_LOOKUP = 3,
  parameter int L3_EXTRA  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              fillValid,
  input  logic              fillLevel,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  output logic              l2Done,
  output logic              l2Hit,
  output logic              l3Done,
  output logic              l3Hit,
  output logic              respValid,
  output logic              respMiss,
  output logic              respFromL3,
  output logic [DATA_W-1:0] respData
);
  localparam int LEVELS = 2;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] holdData;
  logic [LEVELS-1:0] lvDone, lvHit;
  logic [DATA_W-1:0] lvData [LEVELS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addrReg <= '0;
    else if (strb.capture) addrReg <= reqAddr;
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    tag_level_model #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SETS      (SETS),
      .LOOKUP_CYC(L2_LOOKUP + lv * L3_EXTRA)
    ) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (strb.launch),
      .lookAddr(addrReg),
      .fillEn  (fillValid && (fillLevel == 1'(lv))),
      .fillAddr(fillAddr),
      .fillData(fillData),
      .done    (lvDone[lv]),
      .hit     (lvHit[lv]),
      .data    (lvData[lv])
    );
  end

  assign l2Done = lvDone[0];
  assign l2Hit  = lvHit[0];
  assign l3Done = lvDone[1];
  assign l3Hit  = lvHit[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) holdData <= '0;
    else if (strb.loadL2) holdData <= lvData[0];
    else if (strb.loadL3) holdData <= lvData[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid  <= 1'b0;
      respMiss   <= 1'b0;
      respFromL3 <= 1'b0;
      respData   <= '0;
    end else begin
      respValid  <= strb.sendHit || strb.sendMiss;
      respMiss   <= strb.sendMiss;
      respFromL3 <= strb.sendHit && strb.fromL3;
      respData   <= strb.sendHit ? holdData : '0;
    end
  end
endmodule

// File: rtl/fill_control.sv
module fill_control
  import lvl_pkg::*;
#(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reloadPending,
  input  logic             castoutBusy,
  input  logic [LAT_W-1:0] sramLatency,
  input  logic             l2Done,
  input  logic             l2Hit,
  input  logic             l3Done,
  input  logic             l3Hit,
  output logic             reqReady,
  output strobe_t          strb
);
  localparam int CNT_W = LAT_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_LOOK, S_WAIT, S_FWD} state_e;

  state_e           state;
  logic             l2Missed, fwdMiss, fwdL3;
  logic [1:0]       phase;
  logic [1:0]       alignWait;
  logic [CNT_W-1:0] waitCnt, waitLoad;
  logic             arbWin;

  assign arbWin    = !(reloadPending || castoutBusy);
  // Phase after the coming edge is phase+1; cycles to reach phase 0 from there.
  assign alignWait = 2'd3 - phase;
  assign waitLoad  = CNT_W'(alignWait) + CNT_W'(sramLatency);
  assign reqReady  = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 2'd1;
  end

  always_comb begin
    strb = '0;
    unique case (state)
      S_IDLE: strb.capture = reqValid;
      S_ARB:  strb.launch  = arbWin;
      S_LOOK: begin
        strb.loadL2 = l2Done && l2Hit;
        strb.loadL3 = l3Done && l2Missed && l3Hit;
      end
      S_FWD: begin
        strb.sendMiss = fwdMiss;
        strb.sendHit  = !fwdMiss;
        strb.fromL3   = fwdL3;
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      l2Missed <= 1'b0;
      fwdMiss  <= 1'b0;
      fwdL3    <= 1'b0;
      waitCnt  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) state <= S_ARB;
        S_ARB: begin
          l2Missed <= 1'b0;
          if (arbWin) state <= S_LOOK;
        end
        S_LOOK: begin
          if (l2Done) begin
            if (l2Hit) begin
              state   <= S_FWD;
              fwdMiss <= 1'b0;
              fwdL3   <= 1'b0;
            end else begin
              l2Missed <= 1'b1;
            end
          end
          if (l3Done && l2Missed) begin
            if (l3Hit) begin
              fwdMiss <= 1'b0;
              fwdL3   <= 1'b1;
              waitCnt <= waitLoad;
              state   <= (waitLoad == '0) ? S_FWD : S_WAIT;
            end else begin
              fwdMiss <= 1'b1;
              fwdL3   <= 1'b0;
              state   <= S_FWD;
            end
          end
        end
        S_WAIT: begin
          waitCnt <= waitCnt - 1'b1;
          if (waitCnt == CNT_W'(1)) state <= S_FWD;
        end
        S_FWD: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_level_fill_ctrl.sv
module dual_level_fill_ctrl
  import lvl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SETS      = 8,
  parameter int LAT_W     = 6,
  parameter int L2_LOOKUP = 3,
  parameter int L3_EXTRA  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reloadPending,
  input  logic              castoutBusy,
  input  logic [LAT_W-1:0]  sramLatency,
  input  logic              fillValid,
  input  logic              fillLevel,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  output logic              respValid,
  output logic              respMiss,
  output logic              respFromL3,
  output logic [DATA_W-1:0] respData
);
  strobe_t strb;
  logic    l2Done, l2Hit, l3Done, l3Hit;

  fill_control #(.LAT_W(LAT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqValid     (reqValid),
    .reloadPending(reloadPending),
    .castoutBusy  (castoutBusy),
    .sramLatency  (sramLatency),
    .l2Done       (l2Done),
    .l2Hit        (l2Hit),
    .l3Done       (l3Done),
    .l3Hit        (l3Hit),
    .reqReady     (reqReady),
    .strb         (strb)
  );

  fill_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SETS     (SETS),
    .L2_LOOKUP(L2_LOOKUP),
    .L3_EXTRA (L3_EXTRA)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .fillValid (fillValid),
    .fillLevel (fillLevel),
    .fillAddr  (fillAddr),
    .fillData  (fillData),
    .l2Done    (l2Done),
    .l2Hit     (l2Hit),
    .l3Done    (l3Done),
    .l3Hit     (l3Hit),
    .respValid (respValid),
    .respMiss  (respMiss),
    .respFromL3(respFromL3),
    .respData  (respData)
  );
endmodule

// File: rtl/fill_ctrl_checker.sv
module fill_ctrl_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic              respValid,
  input logic              respMiss,
  input logic              respFromL3,
  input logic [DATA_W-1:0] respData
);
  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);
  // R1
  ready_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> reqReady);
  // R8
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |=> !respValid);
  // R8
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (respMiss || respFromL3) |-> respValid);
  // R7
  miss_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && respMiss) |-> (respData == '0 && !respFromL3));
endmodule

bind dual_level_fill_ctrl fill_ctrl_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .respValid (respValid),
  .respMiss  (respMiss),
  .respFromL3(respFromL3),
  .respData  (respData)
);

// File: tb/tb_dual_level_fill_ctrl.sv
`timescale 1ns/1ps
module tb_dual_level_fill_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic        reloadPending = 1'b0;
  logic        castoutBusy = 1'b0;
  logic [5:0]  sramLat = 6'd23;
  logic        fillValid = 1'b0;
  logic        fillLevel = 1'b0;
  logic [15:0] fillAddr = '0;
  logic [31:0] fillData = '0;
  logic        respValid, respMiss, respFromL3;
  logic [31:0] respData;

  always #5 clk = ~clk;

  dual_level_fill_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reloadPending(reloadPending), .castoutBusy(castoutBusy),
    .sramLatency(sramLat), .fillValid(fillValid), .fillLevel(fillLevel),
    .fillAddr(fillAddr), .fillData(fillData), .respValid(respValid),
    .respMiss(respMiss), .respFromL3(respFromL3), .respData(respData)
  );

  int checks = 0;
  int fails = 0;
  int edgeCnt = 0;
  bit chkOn = 0;
  bit done = 0;

  // Reference model state.
  bit          mValid [2][8];
  int unsigned mTag   [2][8];
  int unsigned mData  [2][8];
  bit          pending = 0;
  int          expEdge = 0;
  bit          expMiss, expL3;
  int unsigned expData;
  string       expReq = "R3";

  always @(posedge clk) if (rst_n) edgeCnt++;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (chkOn && !done) begin
      bit expV;
      expV = pending && (edgeCnt == expEdge);
      check(respValid == expV, expReq, "respValid", respValid, expV);
      if (expV) begin
        check(respMiss == expMiss, expReq, "respMiss", respMiss, expMiss);
        check(respFromL3 == expL3, expReq, "respFromL3", respFromL3, expL3);
        check(respData == expData, expReq, "respData", respData, expData);
        pending = 0;
      end
      check(reqReady == !pending, "R1", "reqReady", reqReady, !pending);
    end
  end

  task automatic doFill(input bit lvl, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    fillValid = 1; fillLevel = lvl; fillAddr = a; fillData = d;
    @(negedge clk);
    fillValid = 0;
    mValid[lvl][a[2:0]] = 1;
    mTag[lvl][a[2:0]]   = 32'(a[15:3]);
    mData[lvl][a[2:0]]  = d;
  endtask

  task automatic doReq(input logic [15:0] a, input int k, input bit useCastout,
                       input string req);
    int acc, dEdge, w, idx;
    @(negedge clk);
    reqValid = 1; reqAddr = a;
    @(posedge clk);
    #1;
    acc = edgeCnt;
    idx = int'(a[2:0]);
    dEdge = acc + 5 + k;
    expReq = req;
    if (mValid[0][idx] && mTag[0][idx] == 32'(a[15:3])) begin
      expEdge = dEdge; expMiss = 0; expL3 = 0; expData = mData[0][idx];
    end else if (mValid[1][idx] && mTag[1][idx] == 32'(a[15:3])) begin
      w = (4 - (dEdge % 4)) % 4;
      expEdge = dEdge + w + int'(sramLat) + 1;
      expMiss = 0; expL3 = 1; expData = mData[1][idx];
    end else begin
      expEdge = dEdge + 1; expMiss = 1; expL3 = 0; expData = 0;
    end
    pending = 1;
    @(negedge clk);
    reqValid = 0;
    if (k > 0) begin
      if (useCastout) castoutBusy = 1; else reloadPending = 1;
      repeat (k) @(negedge clk);
      castoutBusy = 0; reloadPending = 0;
    end
    wait (!pending);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 8; s++) mValid[l][s] = 0;
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      check(reqReady == 1, "R9", "reqReady in reset", reqReady, 1);
      check(respValid == 0, "R9", "respValid in reset", respValid, 0);
    end
    rst_n = 1;
    chkOn = 1;

    doFill(0, 16'h0011, 32'hA1A1_0001);
    doFill(0, 16'h0024, 32'hB2B2_0002);
    doFill(1, 16'h0035, 32'hC3C3_0003);
    doFill(1, 16'h0024, 32'hDDDD_0004);
    doFill(1, 16'h0046, 32'hE4E4_0005);

    doReq(16'h0011, 0, 0, "R3");       // second-level hit
    doReq(16'h0024, 0, 0, "R4");       // both hold it, second level wins
    doReq(16'h0011, 2, 0, "R2");       // reload stalls arbitration
    doReq(16'h0011, 1, 1, "R2");       // castout stalls arbitration
    for (int k = 0; k < 4; k++) begin  // R5: third-level hit at varied phases
      repeat (k) @(negedge clk);
      doReq(16'h0035, k, k[0], "R5");
    end
    sramLat = 6'd5;
    doReq(16'h0046, 0, 0, "R6");
    sramLat = 6'd1;
    doReq(16'h0046, 1, 0, "R6");
    doReq(16'h0035, 2, 1, "R6");
    sramLat = 6'd23;
    doReq(16'h0077, 0, 0, "R7");       // miss in both levels
    doReq(16'h0052, 3, 0, "R7");
    doFill(0, 16'h0019, 32'h7777_0019); // R10: replaces index 1
    doReq(16'h0011, 0, 0, "R10");
    doReq(16'h0019, 0, 0, "R10");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule